// File: doc/BRIEF.md
# Debug Hart Availability Gate and Status Summary

This block lives inside the run-control part of a debug module for a small multi-hart system. It holds a two-bit availability register. Each bit marks one of the two lowest-numbered harts as available or unavailable to the debugger. Harts with a higher index have no control bit and always count as available. Marking a hart unavailable changes only what the debugger sees and which requests reach that hart. The hart itself keeps executing.

Each cycle the block forms a selection mask. The mask is the one-hot decode of a single hart-select index, OR'ed with a hart-array mask when array selection is enabled. Halt, resume and reset commands are forwarded only to selected harts that are available. Halt-group propagation from a hart that has just halted reaches only the available, still-running members of its nonzero group. The block also builds six summary flags over the selected harts: all/any halted, all/any running and all/any unavailable. Each selected hart counts in exactly one class. The halted class takes priority over the unavailable class, which takes priority over the running class.

The register port is a flat address/data pair with a write enable. Read data is combinational.

Top module: `hart_avail_top`

## Requirements
- R1: After reset both availability bits are 1 (both controllable harts available), and every resume-acknowledge flag is 1.
- R2: A write to address AVAIL_ADDR (default 0x1f) loads bit 0 of the data as hart 0's availability and bit 1 as hart 1's (1 = available). The new value takes effect on the next clock edge. Commands issued in the same cycle as the write use the old values.
- R3: Harts with index 2 and above always report as available on `hartAvail`, whatever is written to the register.
- R4: Reading AVAIL_ADDR returns hart 0's bit in bit 0 and hart 1's bit in bit 1, with all higher bits zero. Any other address reads as zero.
- R5: A halt command (`cmdStrobe` with `haltReq`) pulses `hartHaltReq` only for selected harts that are available. A selected unavailable hart receives no halt request.
- R6: A resume command pulses `hartResumeReq` only for selected available harts and clears each such hart's `resumeAck` on the next edge. A `resumeDone` pulse sets `resumeAck` again. If both occur in the same cycle, the clear wins.
- R7: A reset command pulses `hartResetReq` only for selected available harts.
- R8: When `haltEvent[i]` pulses and hart i's group is nonzero, `hartHaltReq` pulses in the same cycle for every other hart in that group that is available and not halted. Group 0 never propagates.
- R9: The selection mask is the one-hot of `hartSel`, OR'ed with `hartArrayMask` when `arraySelEn` is 1. A `hartSel` value of NUM_HARTS or more selects no hart by itself.
- R10: For each selected hart, the status logic applies these rules in priority order. A halted hart clears all-running and all-unavailable and sets any-halted. Otherwise, an unavailable hart clears all-running and all-halted and sets any-unavailable. Otherwise, the hart clears all-halted and all-unavailable and sets any-running. The flags follow the inputs in the same cycle.
- R11: With no hart selected, all-halted, all-running and all-unavailable read 1, and the three any-flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | ADDR_W | Register address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Combinational read data |
| hartSel | input | $clog2(NUM_HARTS)+1 | Single hart-select index |
| arraySelEn | input | 1 | Enables the hart-array mask |
| hartArrayMask | input | NUM_HARTS | Additional selected harts |
| cmdStrobe | input | 1 | Run-control command valid |
| haltReq | input | 1 | Command carries a halt |
| resumeReq | input | 1 | Command carries a resume |
| resetReq | input | 1 | Command carries a hart reset |
| haltedIn | input | NUM_HARTS | Per-hart halted state |
| haltEvent | input | NUM_HARTS | Per-hart pulse: hart has just halted |
| haltGroups | input | NUM_HARTS*GROUP_W | Per-hart halt group, hart i in slice i |
| resumeDone | input | NUM_HARTS | Per-hart resume completion pulse |
| hartAvail | output | NUM_HARTS | Availability as the debugger sees it |
| hartHaltReq | output | NUM_HARTS | Gated halt request pulses |
| hartResumeReq | output | NUM_HARTS | Gated resume request pulses |
| hartResetReq | output | NUM_HARTS | Gated reset request pulses |
| resumeAck | output | NUM_HARTS | Per-hart resume-acknowledge flags |
| allHalted | output | 1 | Every selected hart halted |
| anyHalted | output | 1 | Some selected hart halted |
| allRunning | output | 1 | Every selected hart running and available |
| anyRunning | output | 1 | Some selected hart running and available |
| allUnavail | output | 1 | Every selected hart unavailable and not halted |
| anyUnavail | output | 1 | Some selected hart unavailable and not halted |

## Verification
A wrong availability bit shows up in the same cycle it becomes wrong. It appears on `hartAvail` and in the read data, and it either lets a halt, resume or reset pulse through or swallows one, on the very command that uses it. A wrong selection decode or a wrong status priority changes the summary flags combinationally, so it is visible in the same cycle as the faulty input pattern. A wrong resume-acknowledge flag appears one edge after the resume or completion pulse that should have moved it.

// File: rtl/hart_avail_pkg.sv
package hart_avail_pkg;

  // Strobes from the command/register decode to the datapath.
  typedef struct packed {
    logic availWr;   // write the availability register
    logic haltGo;    // halt command for the selected harts
    logic resumeGo;  // resume command for the selected harts
    logic resetGo;   // reset command for the selected harts
  } dmStrobe_t;

endpackage

// File: rtl/hart_avail_ctrl.sv
module hart_avail_ctrl
  import hart_avail_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 32,
  parameter int CTRL_HARTS = 2,
  parameter logic [ADDR_W-1:0] AVAIL_ADDR = 7'h1f
) (
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  regWrEn,
  input  logic                  cmdStrobe,
  input  logic                  haltReq,
  input  logic                  resumeReq,
  input  logic                  resetReq,
  input  logic [CTRL_HARTS-1:0] availBits,
  output dmStrobe_t             strobe,
  output logic [DATA_W-1:0]     regRdData
);

  logic regHit;

  assign regHit = (regAddr == AVAIL_ADDR);

  always_comb begin
    strobe          = '0;
    strobe.availWr  = regWrEn & regHit;
    strobe.haltGo   = cmdStrobe & haltReq;
    strobe.resumeGo = cmdStrobe & resumeReq;
    strobe.resetGo  = cmdStrobe & resetReq;
  end

  // Only the controllable bits are backed by storage; everything else reads zero.
  always_comb begin
    regRdData = '0;
    if (regHit) regRdData[CTRL_HARTS-1:0] = availBits;
  end

endmodule

// File: rtl/hart_avail_dp.sv
module hart_avail_dp
  import hart_avail_pkg::*;
#(
  parameter int NUM_HARTS  = 4,
  parameter int CTRL_HARTS = 2,
  parameter int GROUP_W    = 5,
  parameter int HSEL_W     = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dmStrobe_t                    strobe,
  input  logic [CTRL_HARTS-1:0]        availWrData,
  input  logic [HSEL_W-1:0]            hartSel,
  input  logic                         arraySelEn,
  input  logic [NUM_HARTS-1:0]         hartArrayMask,
  input  logic [NUM_HARTS-1:0]         haltedIn,
  input  logic [NUM_HARTS-1:0]         haltEvent,
  input  logic [NUM_HARTS*GROUP_W-1:0] haltGroups,
  input  logic [NUM_HARTS-1:0]         resumeDone,
  output logic [CTRL_HARTS-1:0]        availBits,
  output logic [NUM_HARTS-1:0]         hartAvail,
  output logic [NUM_HARTS-1:0]         selMask,
  output logic [NUM_HARTS-1:0]         hartHaltReq,
  output logic [NUM_HARTS-1:0]         hartResumeReq,
  output logic [NUM_HARTS-1:0]         hartResetReq,
  output logic [NUM_HARTS-1:0]         resumeAck
);

  logic [CTRL_HARTS-1:0] availReg;
  logic [NUM_HARTS-1:0]  groupHalt;
  logic [NUM_HARTS-1:0]  ackReg;

  // Availability register: both controllable harts start available.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               availReg <= '1;
    else if (strobe.availWr) availReg <= availWrData;
  end

  assign availBits = availReg;

  // Debugger-visible availability: harts past the controllable range are fixed available.
  for (genvar g = 0; g < NUM_HARTS; g++) begin : gAvail
    if (g < CTRL_HARTS) begin : gCtl
      assign hartAvail[g] = availReg[g];
    end else begin : gFixed
      assign hartAvail[g] = 1'b1;
    end
  end

  // Selection: single index decode plus optional array mask.
  always_comb begin
    for (int i = 0; i < NUM_HARTS; i++) begin
      selMask[i] = (hartSel == HSEL_W'(i)) | (arraySelEn & hartArrayMask[i]);
    end
  end

  // Halt-group propagation from harts that have just halted.
  always_comb begin
    for (int j = 0; j < NUM_HARTS; j++) begin
      logic hit;
      hit = 1'b0;
      for (int i = 0; i < NUM_HARTS; i++) begin
        if (i != j && haltEvent[i] &&
            haltGroups[i*GROUP_W +: GROUP_W] == haltGroups[j*GROUP_W +: GROUP_W])
          hit = 1'b1;
      end
      groupHalt[j] = hit && (haltGroups[j*GROUP_W +: GROUP_W] != '0) &&
                     !haltedIn[j] && hartAvail[j];
    end
  end

  assign hartHaltReq   = (({NUM_HARTS{strobe.haltGo}} & selMask) | groupHalt) & hartAvail;
  assign hartResumeReq = {NUM_HARTS{strobe.resumeGo}} & selMask & hartAvail;
  assign hartResetReq  = {NUM_HARTS{strobe.resetGo}}  & selMask & hartAvail;

  // Resume acknowledge: set by completion, cleared by a forwarded resume (clear wins).
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ackReg <= '1;
    else       ackReg <= (ackReg | resumeDone) & ~hartResumeReq;
  end

  assign resumeAck = ackReg;

  // R2: a register write lands on the next edge.
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    strobe.availWr |=> availReg == $past(availWrData));

  // R2: without a write the register holds.
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.availWr |=> $stable(availReg));

  // R5: no halt pulse reaches an unavailable hart.
  a_r5_halt_gated: assert property (@(posedge clk) disable iff (!rstN)
    (hartHaltReq & ~hartAvail) == '0);

  // R6: a forwarded resume leaves the acknowledge clear afterwards.
  a_r6_ack_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (hartResumeReq != '0) |=> ((resumeAck & $past(hartResumeReq)) == '0));

  // R7: reset pulses only for selected harts.
  a_r7_reset_selected: assert property (@(posedge clk) disable iff (!rstN)
    (hartResetReq & ~selMask) == '0);

endmodule

// File: rtl/hart_avail_status.sv
module hart_avail_status #(
  parameter int NUM_HARTS = 4
) (
  input  logic [NUM_HARTS-1:0] selMask,
  input  logic [NUM_HARTS-1:0] haltedIn,
  input  logic [NUM_HARTS-1:0] hartAvail,
  output logic                 allHalted,
  output logic                 anyHalted,
  output logic                 allRunning,
  output logic                 anyRunning,
  output logic                 allUnavail,
  output logic                 anyUnavail
);

  always_comb begin
    allHalted  = 1'b1;
    anyHalted  = 1'b0;
    allRunning = 1'b1;
    anyRunning = 1'b0;
    allUnavail = 1'b1;
    anyUnavail = 1'b0;
    for (int i = 0; i < NUM_HARTS; i++) begin
      if (selMask[i]) begin
        if (haltedIn[i]) begin
          allRunning = 1'b0;
          anyHalted  = 1'b1;
          allUnavail = 1'b0;
        end else if (!hartAvail[i]) begin
          allRunning = 1'b0;
          allHalted  = 1'b0;
          anyUnavail = 1'b1;
        end else begin
          allHalted  = 1'b0;
          allUnavail = 1'b0;
          anyRunning = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/hart_avail_top.sv
module hart_avail_top
  import hart_avail_pkg::*;
#(
  parameter int NUM_HARTS  = 4,
  parameter int CTRL_HARTS = 2,
  parameter int GROUP_W    = 5,
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 32,
  parameter logic [ADDR_W-1:0] AVAIL_ADDR = 7'h1f,
  localparam int HSEL_W    = $clog2(NUM_HARTS) + 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [ADDR_W-1:0]            regAddr,
  input  logic                         regWrEn,
  input  logic [DATA_W-1:0]            regWrData,
  output logic [DATA_W-1:0]            regRdData,
  input  logic [HSEL_W-1:0]            hartSel,
  input  logic                         arraySelEn,
  input  logic [NUM_HARTS-1:0]         hartArrayMask,
  input  logic                         cmdStrobe,
  input  logic                         haltReq,
  input  logic                         resumeReq,
  input  logic                         resetReq,
  input  logic [NUM_HARTS-1:0]         haltedIn,
  input  logic [NUM_HARTS-1:0]         haltEvent,
  input  logic [NUM_HARTS*GROUP_W-1:0] haltGroups,
  input  logic [NUM_HARTS-1:0]         resumeDone,
  output logic [NUM_HARTS-1:0]         hartAvail,
  output logic [NUM_HARTS-1:0]         hartHaltReq,
  output logic [NUM_HARTS-1:0]         hartResumeReq,
  output logic [NUM_HARTS-1:0]         hartResetReq,
  output logic [NUM_HARTS-1:0]         resumeAck,
  output logic                         allHalted,
  output logic                         anyHalted,
  output logic                         allRunning,
  output logic                         anyRunning,
  output logic                         allUnavail,
  output logic                         anyUnavail
);

  dmStrobe_t             strobe;
  logic [CTRL_HARTS-1:0] availBits;
  logic [NUM_HARTS-1:0]  selMask;

  hart_avail_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_HARTS(CTRL_HARTS), .AVAIL_ADDR(AVAIL_ADDR)
  ) ctrl_i (
    .regAddr(regAddr), .regWrEn(regWrEn), .cmdStrobe(cmdStrobe),
    .haltReq(haltReq), .resumeReq(resumeReq), .resetReq(resetReq),
    .availBits(availBits), .strobe(strobe), .regRdData(regRdData)
  );

  hart_avail_dp #(
    .NUM_HARTS(NUM_HARTS), .CTRL_HARTS(CTRL_HARTS), .GROUP_W(GROUP_W), .HSEL_W(HSEL_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .availWrData(regWrData[CTRL_HARTS-1:0]),
    .hartSel(hartSel), .arraySelEn(arraySelEn), .hartArrayMask(hartArrayMask),
    .haltedIn(haltedIn), .haltEvent(haltEvent), .haltGroups(haltGroups),
    .resumeDone(resumeDone), .availBits(availBits), .hartAvail(hartAvail),
    .selMask(selMask), .hartHaltReq(hartHaltReq), .hartResumeReq(hartResumeReq),
    .hartResetReq(hartResetReq), .resumeAck(resumeAck)
  );

  hart_avail_status #(.NUM_HARTS(NUM_HARTS)) status_i (
    .selMask(selMask), .haltedIn(haltedIn), .hartAvail(hartAvail),
    .allHalted(allHalted), .anyHalted(anyHalted), .allRunning(allRunning),
    .anyRunning(anyRunning), .allUnavail(allUnavail), .anyUnavail(anyUnavail)
  );

  // R10: all-running excludes every other class.
  a_r10_running_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    allRunning |-> (!anyHalted && !anyUnavail));

  // R10: all-unavailable excludes halted and running harts.
  a_r10_unavail_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    allUnavail |-> (!anyHalted && !anyRunning));

  // R11: an empty selection leaves the initial flag values.
  a_r11_empty_select: assert property (@(posedge clk) disable iff (!rstN)
    (selMask == '0) |-> (allHalted && allRunning && allUnavail &&
                         !anyHalted && !anyRunning && !anyUnavail));

  // R4: bits above the controllable range always read zero.
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[DATA_W-1:CTRL_HARTS] == '0);

endmodule

// File: tb/hart_avail_top_tb.sv
`timescale 1ns/1ps
module hart_avail_top_tb_top;

  localparam int N   = 4;
  localparam int GW  = 5;
  localparam int HW  = 3;
  localparam logic [6:0] AADDR = 7'h1f;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [6:0]    regAddr = '0;
  logic          regWrEn = 1'b0;
  logic [31:0]   regWrData = '0;
  logic [31:0]   regRdData;
  logic [HW-1:0] hartSel = '0;
  logic          arraySelEn = 1'b0;
  logic [N-1:0]  hartArrayMask = '0;
  logic          cmdStrobe = 1'b0, haltReq = 1'b0, resumeReq = 1'b0, resetReq = 1'b0;
  logic [N-1:0]  haltedIn = '0, haltEvent = '0, resumeDone = '0;
  logic [N*GW-1:0] haltGroups = '0;
  logic [N-1:0]  hartAvail, hartHaltReq, hartResumeReq, hartResetReq, resumeAck;
  logic allHalted, anyHalted, allRunning, anyRunning, allUnavail, anyUnavail;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [1:0]   mAvail;
  logic [N-1:0] mAck;

  always #10 clk = ~clk;

  hart_avail_top dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .hartSel(hartSel), .arraySelEn(arraySelEn),
    .hartArrayMask(hartArrayMask), .cmdStrobe(cmdStrobe), .haltReq(haltReq),
    .resumeReq(resumeReq), .resetReq(resetReq), .haltedIn(haltedIn), .haltEvent(haltEvent),
    .haltGroups(haltGroups), .resumeDone(resumeDone), .hartAvail(hartAvail),
    .hartHaltReq(hartHaltReq), .hartResumeReq(hartResumeReq), .hartResetReq(hartResetReq),
    .resumeAck(resumeAck), .allHalted(allHalted), .anyHalted(anyHalted),
    .allRunning(allRunning), .anyRunning(anyRunning), .allUnavail(allUnavail),
    .anyUnavail(anyUnavail)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] expAvailVec(input logic [1:0] a);
    return {2'b11, a};
  endfunction

  function automatic logic [N-1:0] expSel(input logic [HW-1:0] s, input logic en,
                                          input logic [N-1:0] m);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = (int'(s) == i) || (en && m[i]);
    return r;
  endfunction

  function automatic logic [N-1:0] expGroup(input logic [N*GW-1:0] g, input logic [N-1:0] ev,
                                            input logic [N-1:0] h, input logic [N-1:0] av);
    logic [N-1:0] r;
    for (int j = 0; j < N; j++) begin
      r[j] = 1'b0;
      for (int i = 0; i < N; i++)
        if (i != j && ev[i] && g[i*GW +: GW] == g[j*GW +: GW] && g[j*GW +: GW] != 0 &&
            !h[j] && av[j])
          r[j] = 1'b1;
    end
    return r;
  endfunction

  // {allHalted, anyHalted, allRunning, anyRunning, allUnavail, anyUnavail}
  function automatic logic [5:0] expStatus(input logic [N-1:0] sel, input logic [N-1:0] h,
                                           input logic [N-1:0] av);
    logic aH, nH, aR, nR, aU, nU;
    aH = 1; nH = 0; aR = 1; nR = 0; aU = 1; nU = 0;
    for (int i = 0; i < N; i++) begin
      if (sel[i]) begin
        if (h[i])        begin aR = 0; nH = 1; aU = 0; end
        else if (!av[i]) begin aR = 0; aH = 0; nU = 1; end
        else             begin aH = 0; aU = 0; nR = 1; end
      end
    end
    return {aH, nH, aR, nR, aU, nU};
  endfunction

  // Called #1 after inputs change at a negedge: checks all outputs, then advances the model.
  task automatic step();
    logic [N-1:0] av, sel, eh, er, es;
    #1;
    av  = expAvailVec(mAvail);
    sel = expSel(hartSel, arraySelEn, hartArrayMask);
    eh  = (((cmdStrobe && haltReq) ? sel : '0) | expGroup(haltGroups, haltEvent, haltedIn, av)) & av;
    er  = (cmdStrobe && resumeReq) ? (sel & av) : '0;
    es  = (cmdStrobe && resetReq)  ? (sel & av) : '0;
    check("R3 hartAvail", 32'(hartAvail), 32'(av));
    check("R5 R8 hartHaltReq", 32'(hartHaltReq), 32'(eh));
    check("R6 hartResumeReq", 32'(hartResumeReq), 32'(er));
    check("R7 hartResetReq", 32'(hartResetReq), 32'(es));
    check("R6 resumeAck", 32'(resumeAck), 32'(mAck));
    check("R4 regRdData", regRdData, (regAddr == AADDR) ? {30'b0, mAvail} : 32'b0);
    check("R10 status", 32'({allHalted, anyHalted, allRunning, anyRunning, allUnavail, anyUnavail}),
          32'(expStatus(sel, haltedIn, av)));
    if (regWrEn && regAddr == AADDR) mAvail = regWrData[1:0];
    mAck = (mAck | resumeDone) & ~er;
  endtask

  task automatic idle();
    regWrEn = 0; cmdStrobe = 0; haltReq = 0; resumeReq = 0; resetReq = 0;
    haltEvent = '0; resumeDone = '0; arraySelEn = 0; hartArrayMask = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    mAvail = 2'b11;
    mAck = '1;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset values.
    @(negedge clk);
    idle(); regAddr = AADDR; hartSel = 3'd0;
    #1;
    check("R1 avail after reset", regRdData, 32'h3);
    check("R1 resumeAck after reset", 32'(resumeAck), 32'hf);
    step();

    // R11 / R9: out-of-range index and no array mask -> empty selection.
    @(negedge clk);
    idle(); hartSel = 3'd7; cmdStrobe = 1; haltReq = 1; haltedIn = 4'b0101;
    #1;
    check("R11 empty status", 32'({allHalted, anyHalted, allRunning, anyRunning, allUnavail, anyUnavail}),
          32'b101010);
    check("R9 out-of-range select no halt", 32'(hartHaltReq), 32'h0);
    step();

    // R2: write hart 0 unavailable with a same-cycle halt to hart 0 -> old value used.
    @(negedge clk);
    idle(); haltedIn = '0; hartSel = 3'd0; regAddr = AADDR; regWrEn = 1; regWrData = 32'h2;
    cmdStrobe = 1; haltReq = 1;
    #1;
    check("R2 same-cycle halt uses old availability", 32'(hartHaltReq), 32'h1);
    step();

    // R5 / R10 / R4: hart 0 now unavailable.
    @(negedge clk);
    idle(); hartSel = 3'd0; regAddr = AADDR; cmdStrobe = 1; haltReq = 1;
    #1;
    check("R5 halt blocked on unavailable hart", 32'(hartHaltReq), 32'h0);
    check("R4 readback after write", regRdData, 32'h2);
    check("R10 unavailable selected hart", 32'({allHalted, anyHalted, allRunning, anyRunning, allUnavail, anyUnavail}),
          32'b000011);
    step();

    // R3: clearing both bits leaves harts 2 and 3 available.
    @(negedge clk);
    idle(); regAddr = AADDR; regWrEn = 1; regWrData = 32'hffff_fffc;
    step();
    @(negedge clk);
    idle(); regAddr = 7'h10;
    #1;
    check("R3 upper harts fixed available", 32'(hartAvail), 32'hc);
    check("R4 other address reads zero", regRdData, 32'h0);
    step();

    // R8: hart 1 unavailable, group 1 = harts 0,1,2; hart 3 in group 0; hart 2 halts.
    @(negedge clk);
    idle(); regAddr = AADDR; regWrEn = 1; regWrData = 32'h1;
    step();
    @(negedge clk);
    idle(); hartSel = 3'd7;
    haltGroups = {5'd0, 5'd1, 5'd1, 5'd1}; haltedIn = 4'b0100; haltEvent = 4'b0100;
    #1;
    check("R8 group propagation to available members", 32'(hartHaltReq), 32'h1);
    step();
    @(negedge clk);
    idle(); hartSel = 3'd7; haltGroups = '0; haltedIn = 4'b0001; haltEvent = 4'b0001;
    #1;
    check("R8 group zero never propagates", 32'(hartHaltReq), 32'h0);
    step();

    // R6: resume to hart 3 clears its ack; resumeDone sets it again.
    @(negedge clk);
    idle(); haltedIn = '0; hartSel = 3'd3; cmdStrobe = 1; resumeReq = 1;
    step();
    @(negedge clk);
    idle();
    #1;
    check("R6 ack cleared by resume", 32'(resumeAck[3]), 32'h0);
    resumeDone = 4'b1000;
    step();
    @(negedge clk);
    idle();
    #1;
    check("R6 ack set by resumeDone", 32'(resumeAck[3]), 32'h1);
    step();

    // Random stimulus.
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      regAddr       = ($urandom % 3 != 0) ? AADDR : 7'($urandom);
      regWrEn       = ($urandom % 6 == 0);
      regWrData     = $urandom;
      hartSel       = HW'($urandom);
      arraySelEn    = ($urandom % 2 == 0);
      hartArrayMask = N'($urandom);
      cmdStrobe     = ($urandom % 2 == 0);
      haltReq       = ($urandom % 2 == 0);
      resumeReq     = ($urandom % 2 == 0);
      resetReq      = ($urandom % 3 == 0);
      haltedIn      = N'($urandom);
      haltEvent     = N'($urandom) & N'($urandom);
      resumeDone    = N'($urandom) & N'($urandom);
      for (int h = 0; h < N; h++) haltGroups[h*GW +: GW] = GW'($urandom % 3);
      step();
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule